// File: doc/BRIEF.md
# Register Rename Stage with Zeroing-Idiom Elimination

This block is the rename step between an in-order front end and an out-of-order core. It accepts one decoded instruction per cycle. Each instruction carries an architectural destination, two architectural sources, a two-bit operation class and a valid strobe. The block reads the physical tags of both sources from a map table. It takes a fresh physical tag for the destination from a circular free list, and it reports the tag the destination held before, so that tag can be freed later.

Some instructions always produce zero, whatever their inputs hold: an exclusive-OR or a subtract whose two sources name the same architectural register. The block resolves these at rename. The destination is pointed at physical tag 0, which is wired to zero and never sits in the free list. No free tag is consumed, and the instruction is flagged as not to be dispatched. It therefore uses no reorder-buffer entry and no execution slot. Later readers of that register see tag 0 and no longer wait on the register's earlier producer.

A release port hands one physical tag per cycle back to the tail of the free list. When an instruction needs a tag and the list is empty, the ready output drops and the instruction is held off.

Top module: `rename_stage`

## Requirements
- R1: Synchronous reset maps architectural register i to physical tag i+1. It loads the free list with tags ARCH_REGS+1 up to PHYS_REGS-1, to be handed out in ascending order. After reset, outValid is low and inReady is high.
- R2: An accepted instruction of class ALU (inOp 2'b00) receives the free-list head as outDstTag. It reports the destination's previous tag as outOldTag and sets outDispatch to 1.
- R3: An accepted instruction of class XOR (2'b01) or SUB (2'b10) whose two sources are equal is a zeroing idiom. It gives outDstTag 0 and outDispatch 0, reports the destination's previous tag as outOldTag, and consumes no free tag.
- R4: An XOR or SUB whose sources differ is renamed like R2. Its source tags are the current mappings of both sources.
- R5: After a zeroing idiom on register r, a later instruction that reads r gets source tag 0.
- R6: Source tags are read before the same instruction's destination is updated. The new mapping is seen by the instruction accepted in the next cycle.
- R7: While the free list is empty, inReady is low for an instruction that needs a new tag, and that instruction is not accepted. Idioms and class NODEST (2'b11) stay accepted.
- R8: A release with relValid high appends relTag to the free-list tail, and released tags are handed out in release order. A release of tag 0 has no effect.
- R9: An accepted NODEST instruction consumes no tag and leaves the map table unchanged. It reports outDstTag 0 and outOldTag 0 with outDispatch 1.
- R10: The outputs of an instruction accepted at a clock edge appear with outValid high just after that edge. outValid is low after any edge with no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction present |
| inOp | input | 2 | Class: 00 ALU, 01 XOR, 10 SUB, 11 no destination |
| inDst | input | $clog2(ARCH_REGS) | Architectural destination |
| inSrc1 | input | $clog2(ARCH_REGS) | First architectural source |
| inSrc2 | input | $clog2(ARCH_REGS) | Second architectural source |
| relValid | input | 1 | Tag release strobe |
| relTag | input | $clog2(PHYS_REGS) | Tag returned to the free list |
| inReady | output | 1 | Instruction can be accepted this cycle |
| outValid | output | 1 | Renamed result present |
| outDispatch | output | 1 | Send to dispatch (low for eliminated idioms) |
| outSrc1Tag | output | $clog2(PHYS_REGS) | Physical tag of source 1 |
| outSrc2Tag | output | $clog2(PHYS_REGS) | Physical tag of source 2 |
| outDstTag | output | $clog2(PHYS_REGS) | New physical destination tag |
| outOldTag | output | $clog2(PHYS_REGS) | Previous destination tag, for later release |

## Verification
The bench builds the block with four architectural registers and eight physical tags. Only three tags are free after reset, so three renames drain the list. This brings into reach the empty-list stall, idioms and no-destination instructions accepted while stalled, a release of tag 0 that leaves the stall in place, and the order in which released tags are handed out again. A long random stretch then recycles every reported old tag through the release port, which wraps the circular pointers many times.

// File: rtl/rename_pkg.sv
package rename_pkg;

  typedef enum logic [1:0] {
    OP_ALU    = 2'b00,
    OP_XOR    = 2'b01,
    OP_SUB    = 2'b10,
    OP_NODEST = 2'b11
  } opClass_e;

  // strobes from the control to the datapath and free list
  typedef struct packed {
    logic accept;    // instruction taken this cycle
    logic alloc;     // a fresh tag is popped
    logic writeMap;  // map table entry of the destination is written
    logic idiom;     // zeroing idiom, dropped before dispatch
    logic hasDst;    // class writes a destination
  } renCtrl_t;

endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          inValid,
  input  logic [1:0]    inOp,
  input  logic [AW-1:0] inSrc1,
  input  logic [AW-1:0] inSrc2,
  input  logic          flEmpty,
  output logic          inReady,
  output renCtrl_t      ctrl
);

  opClass_e opClass;
  logic     sameSrc;
  logic     zeroIdiom;
  logic     writesDst;
  logic     needTag;

  always_comb begin
    opClass   = opClass_e'(inOp);
    sameSrc   = (inSrc1 == inSrc2);
    zeroIdiom = sameSrc && ((opClass == OP_XOR) || (opClass == OP_SUB));
    writesDst = (opClass != OP_NODEST);
    needTag   = writesDst && !zeroIdiom;
    inReady   = !(needTag && flEmpty);

    ctrl.accept   = inValid && inReady;
    ctrl.alloc    = inValid && inReady && needTag;
    ctrl.writeMap = inValid && inReady && writesDst;
    ctrl.idiom    = zeroIdiom;
    ctrl.hasDst   = writesDst;
  end

endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int PHYS_REGS = 64,
  parameter int ARCH_REGS = 15
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pop,
  input  logic                         push,
  input  logic [$clog2(PHYS_REGS)-1:0] pushTag,
  output logic [$clog2(PHYS_REGS)-1:0] headTag,
  output logic                         empty
);

  localparam int TW   = $clog2(PHYS_REGS);
  localparam int CAP  = PHYS_REGS - 1;          // every tag except the zero tag
  localparam int PW   = $clog2(CAP);
  localparam int CW   = $clog2(CAP + 1);
  localparam int INIT = PHYS_REGS - 1 - ARCH_REGS;

  logic [TW-1:0] slots [CAP];
  logic [PW-1:0] headPtr;
  logic [PW-1:0] tailPtr;
  logic [CW-1:0] count;
  logic          doPush;
  logic          doPop;

  function automatic logic [PW-1:0] stepPtr(input logic [PW-1:0] p);
    return (p == PW'(CAP - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush  = push && (pushTag != '0) && (count != CW'(CAP));
  assign doPop   = pop && (count != '0);
  assign headTag = slots[headPtr];
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < CAP; k++) begin
        slots[k] <= (k < INIT) ? TW'(ARCH_REGS + 1 + k) : '0;
      end
      headPtr <= '0;
      tailPtr <= PW'(INIT);
      count   <= CW'(INIT);
    end else begin
      if (doPush) begin
        slots[tailPtr] <= pushTag;
        tailPtr        <= stepPtr(tailPtr);
      end
      if (doPop) begin
        headPtr <= stepPtr(headPtr);
      end
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 15,
  parameter int PHYS_REGS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  renCtrl_t                     ctrl,
  input  logic [$clog2(ARCH_REGS)-1:0] inDst,
  input  logic [$clog2(ARCH_REGS)-1:0] inSrc1,
  input  logic [$clog2(ARCH_REGS)-1:0] inSrc2,
  input  logic [$clog2(PHYS_REGS)-1:0] newTag,
  output logic                         outValid,
  output logic                         outDispatch,
  output logic [$clog2(PHYS_REGS)-1:0] outSrc1Tag,
  output logic [$clog2(PHYS_REGS)-1:0] outSrc2Tag,
  output logic [$clog2(PHYS_REGS)-1:0] outDstTag,
  output logic [$clog2(PHYS_REGS)-1:0] outOldTag
);

  localparam int TW = $clog2(PHYS_REGS);

  logic [TW-1:0] mapTable [ARCH_REGS];
  logic [TW-1:0] dstTag;

  // idioms and no-destination classes never allocate, so they land on tag 0
  assign dstTag = ctrl.alloc ? newTag : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        mapTable[i] <= TW'(i + 1);
      end
    end else if (ctrl.writeMap) begin
      mapTable[inDst] <= dstTag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      outDispatch <= 1'b0;
      outSrc1Tag  <= '0;
      outSrc2Tag  <= '0;
      outDstTag   <= '0;
      outOldTag   <= '0;
    end else begin
      outValid <= ctrl.accept;
      if (ctrl.accept) begin
        outDispatch <= !ctrl.idiom;
        outSrc1Tag  <= mapTable[inSrc1];
        outSrc2Tag  <= mapTable[inSrc2];
        outDstTag   <= dstTag;
        outOldTag   <= ctrl.hasDst ? mapTable[inDst] : '0;
      end
    end
  end

endmodule

// File: rtl/rename_stage.sv
module rename_stage
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 15,
  parameter int PHYS_REGS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic [1:0]                   inOp,
  input  logic [$clog2(ARCH_REGS)-1:0] inDst,
  input  logic [$clog2(ARCH_REGS)-1:0] inSrc1,
  input  logic [$clog2(ARCH_REGS)-1:0] inSrc2,
  input  logic                         relValid,
  input  logic [$clog2(PHYS_REGS)-1:0] relTag,
  output logic                         inReady,
  output logic                         outValid,
  output logic                         outDispatch,
  output logic [$clog2(PHYS_REGS)-1:0] outSrc1Tag,
  output logic [$clog2(PHYS_REGS)-1:0] outSrc2Tag,
  output logic [$clog2(PHYS_REGS)-1:0] outDstTag,
  output logic [$clog2(PHYS_REGS)-1:0] outOldTag
);

  localparam int AW = $clog2(ARCH_REGS);
  localparam int TW = $clog2(PHYS_REGS);

  renCtrl_t      ctrl;
  logic          flEmpty;
  logic [TW-1:0] headTag;

  rename_ctrl #(.AW(AW)) ctrl_i (
    .inValid (inValid),
    .inOp    (inOp),
    .inSrc1  (inSrc1),
    .inSrc2  (inSrc2),
    .flEmpty (flEmpty),
    .inReady (inReady),
    .ctrl    (ctrl)
  );

  rename_freelist #(.PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS)) freelist_i (
    .clk     (clk),
    .rst     (rst),
    .pop     (ctrl.alloc),
    .push    (relValid),
    .pushTag (relTag),
    .headTag (headTag),
    .empty   (flEmpty)
  );

  rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) map_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .inDst       (inDst),
    .inSrc1      (inSrc1),
    .inSrc2      (inSrc2),
    .newTag      (headTag),
    .outValid    (outValid),
    .outDispatch (outDispatch),
    .outSrc1Tag  (outSrc1Tag),
    .outSrc2Tag  (outSrc2Tag),
    .outDstTag   (outDstTag),
    .outOldTag   (outOldTag)
  );

endmodule

// File: rtl/rename_stage_chk.sv
module rename_stage_chk #(
  parameter int ARCH_REGS = 15,
  parameter int PHYS_REGS = 64
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         inValid,
  input logic [1:0]                   inOp,
  input logic [$clog2(ARCH_REGS)-1:0] inSrc1,
  input logic [$clog2(ARCH_REGS)-1:0] inSrc2,
  input logic                         inReady,
  input logic                         outValid,
  input logic                         outDispatch,
  input logic [$clog2(PHYS_REGS)-1:0] outDstTag,
  input logic [$clog2(PHYS_REGS)-1:0] outOldTag
);

  logic taken;
  assign taken = inValid && inReady;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    taken |=> outValid) else $error("accepted instruction produced no output"); // R10

  AST_NO_GHOST_OUT: assert property (@(posedge clk) disable iff (rst)
    !taken |=> !outValid) else $error("output without acceptance"); // R10

  AST_IDIOM_ZEROED: assert property (@(posedge clk) disable iff (rst)
    taken && (inOp == 2'b01 || inOp == 2'b10) && (inSrc1 == inSrc2)
    |=> !outDispatch && (outDstTag == '0)) else $error("idiom not eliminated"); // R3

  AST_DIFF_SRC_NORMAL: assert property (@(posedge clk) disable iff (rst)
    taken && (inOp == 2'b01 || inOp == 2'b10) && (inSrc1 != inSrc2)
    |=> outDispatch && (outDstTag != '0)) else $error("non-idiom eliminated"); // R4

  AST_NODEST_CLEAN: assert property (@(posedge clk) disable iff (rst)
    taken && (inOp == 2'b11)
    |=> outDispatch && (outDstTag == '0) && (outOldTag == '0)) else $error("no-dest tags"); // R9

  AST_IDIOM_NEVER_STALLS: assert property (@(posedge clk) disable iff (rst)
    (inOp != 2'b00) && (inSrc1 == inSrc2) && (inOp != 2'b11) |-> inReady)
    else $error("idiom held off"); // R7

endmodule

bind rename_stage rename_stage_chk #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .inOp        (inOp),
  .inSrc1      (inSrc1),
  .inSrc2      (inSrc2),
  .inReady     (inReady),
  .outValid    (outValid),
  .outDispatch (outDispatch),
  .outDstTag   (outDstTag),
  .outOldTag   (outOldTag)
);

// File: tb/rename_stage_tb_top.sv
`timescale 1ns/1ps
module rename_stage_tb_top;

  localparam int ARCH = 4;
  localparam int PHYS = 8;
  localparam int AW   = $clog2(ARCH);
  localparam int TW   = $clog2(PHYS);

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic [1:0]    inOp;
  logic [AW-1:0] inDst, inSrc1, inSrc2;
  logic          relValid;
  logic [TW-1:0] relTag;
  logic          inReady, outValid, outDispatch;
  logic [TW-1:0] outSrc1Tag, outSrc2Tag, outDstTag, outOldTag;

  always #4 clk = ~clk;

  rename_stage #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp), .inDst(inDst),
    .inSrc1(inSrc1), .inSrc2(inSrc2), .relValid(relValid), .relTag(relTag),
    .inReady(inReady), .outValid(outValid), .outDispatch(outDispatch),
    .outSrc1Tag(outSrc1Tag), .outSrc2Tag(outSrc2Tag), .outDstTag(outDstTag),
    .outOldTag(outOldTag)
  );

  typedef struct {
    int    s1, s2, dst, old;
    bit    disp;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int       mdlMap[ARCH];
  int       mdlFree[$];
  int       relPend[$];
  int       errors = 0;
  int       checks = 0;
  bit       done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compares every produced result with the scoreboard head
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && outValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R10", "unexpected outValid", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(outSrc1Tag == TW'(e.s1) && outSrc2Tag == TW'(e.s2) &&
              outDstTag == TW'(e.dst) && outOldTag == TW'(e.old) &&
              outDispatch == e.disp, e.req,
              $sformatf("tags s1/s2/dst/old/disp %0d/%0d/%0d/%0d/%0d vs", outSrc1Tag,
                        outSrc2Tag, outDstTag, outOldTag, outDispatch),
              {e.s1, e.s2, e.dst, e.old}, int'(e.disp));
        end
      end
    end
  end

  // driver: one cycle of stimulus plus model update
  task automatic step(input bit v, input int op, input int d, input int a, input int b,
                      input bit rv, input int rt, input string req);
    bit idiom, hasDst, alloc, expReady;
    @(negedge clk);
    inValid  = v;
    inOp     = 2'(op);
    inDst    = AW'(d);
    inSrc1   = AW'(a);
    inSrc2   = AW'(b);
    relValid = rv;
    relTag   = TW'(rt);
    idiom    = (op == 1 || op == 2) && (a == b);
    hasDst   = (op != 3);
    alloc    = hasDst && !idiom;
    expReady = !(alloc && mdlFree.size() == 0);
    #1;
    if (v) chk(inReady == expReady, expReady ? req : "R7", "inReady", int'(inReady), int'(expReady));
    @(posedge clk);
    if (v && expReady) begin
      expItem_t e;
      e.s1   = mdlMap[a];
      e.s2   = mdlMap[b];
      e.dst  = alloc ? mdlFree.pop_front() : 0;
      e.old  = hasDst ? mdlMap[d] : 0;
      e.disp = !idiom;
      e.req  = req;
      expQ.push_back(e);
      if (hasDst) mdlMap[d] = e.dst;
      if (e.old != 0) relPend.push_back(e.old);
    end
    if (rv && rt != 0) mdlFree.push_back(rt);
  endtask

  task automatic idle(input bit rv, input int rt);
    step(1'b0, 0, 0, 0, 0, rv, rt, "R8");
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inOp = '0; inDst = '0; inSrc1 = '0; inSrc2 = '0;
    relValid = 1'b0; relTag = '0;
    for (int i = 0; i < ARCH; i++) mdlMap[i] = i + 1;
    for (int t = ARCH + 1; t < PHYS; t++) mdlFree.push_back(t);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(outValid == 1'b0, "R10", "outValid after reset", int'(outValid), 0);
    chk(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);

    step(1, 0, 1, 2, 3, 0, 0, "R1");   // src 3,4 dst 5 old 2
    step(1, 0, 2, 1, 1, 0, 0, "R6");   // sees r1 -> 5 next cycle
    step(1, 0, 3, 3, 0, 0, 0, "R6");   // own source read before update
    step(1, 0, 0, 1, 2, 0, 0, "R7");   // list empty: held off
    step(1, 1, 0, 0, 0, 0, 0, "R3");   // XOR idiom accepted while empty
    step(1, 3, 0, 0, 2, 0, 0, "R5");   // reads r0 -> tag 0, no dest (R9)
    idle(1, 0);                        // release of tag 0 ignored
    step(1, 0, 1, 2, 3, 0, 0, "R8");   // still stalled after tag 0 release
    idle(1, relPend.pop_front());      // release old tag 2
    step(1, 1, 2, 1, 3, 0, 0, "R4");   // XOR with distinct sources
    step(1, 2, 1, 1, 1, 0, 0, "R3");   // SUB idiom
    step(1, 0, 3, 1, 1, 1, relPend.pop_front(), "R7"); // release same cycle does not help
    step(1, 0, 3, 1, 1, 0, 0, "R5");   // reads idiom result, gets tag 0
    while (relPend.size() > 0) idle(1, relPend.pop_front());
    step(1, 0, 0, 3, 2, 0, 0, "R8");   // reuse in release order
    step(1, 0, 1, 0, 0, 0, 0, "R8");
    step(1, 2, 2, 0, 1, 0, 0, "R4");   // SUB distinct sources
    step(1, 3, 0, 2, 1, 0, 0, "R9");

    for (int n = 0; n < 400; n++) begin
      bit rv;
      int rt;
      rv = (relPend.size() > 0) && ($urandom_range(0, 2) != 0);
      rt = rv ? relPend.pop_front() : 0;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, ARCH - 1),
           $urandom_range(0, ARCH - 1), $urandom_range(0, ARCH - 1), rv, rt, "R2");
    end
    idle(0, 0);
    idle(0, 0);
    chk(expQ.size() == 0, "R10", "results outstanding", expQ.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R10", "watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule